// File: doc/BRIEF.md
# Gate-Driver Serial Message Handler

This block sits on the isolated secondary side of a power-transistor gate driver and answers the inverter controller over a four-wire SPI link. SPI mode 0 is used, with 16-bit words sent MSB first and sampled on the rising clock edge. An active-low select line frames each transfer, and each asserting edge of that line restarts word counting. The block works out the message kind from the first incoming word and runs one of three services: storing a driver parameter, reading back a parameter or a monitored variable, or the periodic exchange done once per modulation cycle. The periodic exchange returns the phase current and one addressed monitoring item.

Every frame has four words. The first outgoing word is always the driver status word. The last outgoing word is a checksum chosen so that the four outgoing words add to zero modulo 2^16. In the read and periodic frames the controller places its own checksum in the third word. If that incoming checksum fails, the driver inverts its outgoing checksum. The controller therefore learns at the end of the same transfer that the exchange was bad. A parameter write is kept only when the whole frame is well formed. A bad write raises an error flag in the status word.

Top module: `drvspi_msg_handler`

## Requirements
- R1: After reset `spi_miso` is 0 while the select line is high, and every stored parameter on `param_bus` reads 0.
- R2: The first outgoing word of every frame is the status word: bit 15 is the write-error flag, bits FLAG_W-1..0 are `prot_flags` as sampled at select assertion, and all other bits are 0. Words go out MSB first and are valid before each rising SCLK edge.
- R3: A write frame has the words ID=0x0001, address, value and checksum. The four words must sum to 0. The address must be below NUM_PARAMS. The frame must be exactly four whole words. When all of this holds, the value is stored at the address once select is released, and the error flag clears.
- R4: A write frame of correct length whose checksum fails, or whose address is NUM_PARAMS or above, changes no parameter and sets the error flag (status bit 15). The flag stays set until the next good write.
- R5: A read frame has the words ID=0x0002, address, checksum and pad. Its third outgoing word is the stored parameter when the address is below NUM_PARAMS. Otherwise it is the monitored variable at that address, taken from `cyc_value` while `cyc_index` holds the address.
- R6: A periodic frame has the words ID=0x0003, item index, checksum and pad. Its second outgoing word is `phase_current`. Its third outgoing word is `cyc_value` for the index received in word 1.
- R7: The fourth outgoing word equals 0 minus the sum of outgoing words 0 to 2, taken modulo 2^16.
- R8: In a read or periodic frame where incoming words 0 to 2 do not sum to 0, the fourth outgoing word is the bitwise inverse of the R7 value.
- R9: A write frame with fewer than four words, with a partial word, or with more than four words changes no parameter and does not change the error flag. Any outgoing word after the fourth is 0.
- R10: A frame with any other ID returns 0 in outgoing words 1 and 2, keeps the R7 checksum, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI inputs are oversampled in this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the controller, idle low |
| spi_cs_n | input | 1 | Active-low select that frames each transfer |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller, 0 while deselected |
| prot_flags | input | FLAG_W | Protection and limit-exceeded flags for the status word |
| phase_current | input | 16 | Latest phase current sample |
| cyc_index | output | 16 | Index of the monitored item being requested |
| cyc_value | input | 16 | Value of the monitored item at `cyc_index` |
| param_bus | output | NUM_PARAMS*16 | All stored parameters, parameter k in bits 16k+15..16k |

## Verification
A wrong word counter or a wrong decoded ID shows up within one frame. It appears as a misplaced current or item value in outgoing words 1 and 2, or as a checksum that does not close in word 3. A corrupted running sum on either side shows up in that same frame's final word, because it flips between the R7 value and its inverse. A faulty commit decision only becomes visible after select is released. It shows on `param_bus` within a few clocks, and in the next frame's status bit 15 and read-back word. The bench therefore follows every write with a readback and a status check.

// File: rtl/drvspi_pkg.sv
package drvspi_pkg;
   localparam int WORD_W = 16;
   typedef logic [WORD_W-1:0] word_t;

   localparam word_t MSG_WRITE = 16'h0001;
   localparam word_t MSG_READ  = 16'h0002;
   localparam word_t MSG_EXCH  = 16'h0003;

   localparam int FRAME_WORDS = 4;
endpackage

// File: rtl/drvspi_phy.sv
module drvspi_phy
   import drvspi_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk,
   input  logic  cs_n,
   input  logic  mosi,
   output logic  miso,
   output logic  frame_start,
   output logic  frame_end,
   output logic  word_valid,
   output word_t rx_word,
   output logic  aligned,
   output logic  tx_load,
   input  word_t tx_first,
   input  word_t tx_next
);
   localparam int BIT_CW = $clog2(WORD_W);

   logic [SYNC_STAGES:0]   sclk_p;
   logic [SYNC_STAGES:0]   cs_p;
   logic [SYNC_STAGES-1:0] mosi_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= '0;
         cs_p   <= '1;
         mosi_p <= '0;
      end else begin
         sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk};
         cs_p   <= {cs_p[SYNC_STAGES-1:0], cs_n};
         mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
      end
   end

   logic sc_now, sc_prev, sel_now, sel_prev, mosi_b;
   logic rise, fall;
   assign sc_now   = sclk_p[SYNC_STAGES-1];
   assign sc_prev  = sclk_p[SYNC_STAGES];
   assign sel_now  = ~cs_p[SYNC_STAGES-1];
   assign sel_prev = ~cs_p[SYNC_STAGES];
   assign mosi_b   = mosi_p[SYNC_STAGES-1];
   assign rise     = sc_now & ~sc_prev;
   assign fall     = ~sc_now & sc_prev;

   assign frame_start = sel_now & ~sel_prev;
   assign frame_end   = ~sel_now & sel_prev;

   logic [BIT_CW-1:0] bit_cnt;
   word_t             in_sr;
   word_t             out_sr;
   logic              load_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         in_sr      <= '0;
         out_sr     <= '0;
         load_pend  <= 1'b0;
         word_valid <= 1'b0;
         rx_word    <= '0;
      end else begin
         word_valid <= 1'b0;
         if (frame_start) begin
            bit_cnt   <= '0;
            in_sr     <= '0;
            out_sr    <= tx_first;
            load_pend <= 1'b0;
         end else if (sel_now) begin
            if (rise) begin
               in_sr   <= {in_sr[WORD_W-2:0], mosi_b};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == BIT_CW'(WORD_W-1)) begin
                  word_valid <= 1'b1;
                  rx_word    <= {in_sr[WORD_W-2:0], mosi_b};
                  load_pend  <= 1'b1;
               end
            end
            if (fall) begin
               if (load_pend) begin
                  out_sr    <= tx_next;
                  load_pend <= 1'b0;
               end else begin
                  out_sr <= {out_sr[WORD_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign aligned = (bit_cnt == '0);
   assign tx_load = sel_now & fall & load_pend;
   assign miso    = sel_now ? out_sr[WORD_W-1] : 1'b0;
endmodule

// File: rtl/drvspi_params.sv
module drvspi_params
   import drvspi_pkg::*;
#(
   parameter int NUM_PARAMS = 16,
   parameter int ADDR_W     = $clog2(NUM_PARAMS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  word_t                        wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output word_t                        rd_data,
   output logic [NUM_PARAMS*WORD_W-1:0] params_flat
);
   for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_reg
      word_t val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(g))
            val_q <= wr_data;
      end
      assign params_flat[g*WORD_W +: WORD_W] = val_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_PARAMS; i++) begin
         if (rd_addr == ADDR_W'(i))
            rd_data = params_flat[i*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/drvspi_engine.sv
module drvspi_engine
   import drvspi_pkg::*;
#(
   parameter int NUM_PARAMS = 16,
   parameter int FLAG_W     = 8,
   parameter int ADDR_W     = $clog2(NUM_PARAMS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              word_valid,
   input  word_t             rx_word,
   input  logic              aligned,
   input  logic              tx_load,
   input  logic [FLAG_W-1:0] flags,
   input  word_t             cur_sample,
   input  word_t             cyc_data,
   input  word_t             rd_param,
   output word_t             status,
   output word_t             tx_next,
   output word_t             cyc_idx,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output word_t             wr_data
);
   localparam int WC_W = 3;
   localparam logic [WC_W-1:0] WC_MAX  = '1;
   localparam logic [WC_W-1:0] WC_FULL = WC_W'(FRAME_WORDS);

   logic [WC_W-1:0] wcnt;
   word_t           id_q, addr_q, val_q;
   word_t           rx_sum, tx_sum;
   logic            err_q;

   logic is_write, is_read, is_exch, in_range, len_ok, sum_ok, in_bad;
   assign is_write = (id_q == MSG_WRITE);
   assign is_read  = (id_q == MSG_READ);
   assign is_exch  = (id_q == MSG_EXCH);
   assign in_range = (addr_q < word_t'(NUM_PARAMS));
   assign len_ok   = (wcnt == WC_FULL) && aligned;
   assign sum_ok   = (rx_sum == '0);
   assign in_bad   = (is_read || is_exch) && !sum_ok;

   logic wr_judge;
   assign wr_judge = frame_end && is_write && len_ok;
   assign wr_en    = wr_judge && sum_ok && in_range;
   assign wr_addr  = addr_q[ADDR_W-1:0];
   assign wr_data  = val_q;
   assign rd_addr  = addr_q[ADDR_W-1:0];
   assign cyc_idx  = addr_q;

   always_comb begin
      status = '0;
      status[FLAG_W-1:0] = flags;
      status[WORD_W-1]   = err_q;
   end

   always_comb begin
      case (wcnt)
         3'd1:    tx_next = is_exch ? cur_sample : '0;
         3'd2:    tx_next = is_exch ? cyc_data :
                            is_read ? (in_range ? rd_param : cyc_data) : '0;
         3'd3:    tx_next = (word_t'(0) - tx_sum) ^ (in_bad ? '1 : '0);
         default: tx_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt   <= '0;
         id_q   <= '0;
         addr_q <= '0;
         val_q  <= '0;
         rx_sum <= '0;
         tx_sum <= '0;
         err_q  <= 1'b0;
      end else begin
         if (frame_start) begin
            wcnt   <= '0;
            id_q   <= '0;
            rx_sum <= '0;
            tx_sum <= status;
         end else begin
            if (word_valid) begin
               if (wcnt != WC_MAX)
                  wcnt <= wcnt + 1'b1;
               rx_sum <= rx_sum + rx_word;
               case (wcnt)
                  3'd0:    id_q   <= rx_word;
                  3'd1:    addr_q <= rx_word;
                  3'd2:    val_q  <= rx_word;
                  default: ;
               endcase
            end
            if (tx_load)
               tx_sum <= tx_sum + tx_next;
         end
         if (wr_judge)
            err_q <= !(sum_ok && in_range);
      end
   end
endmodule

// File: rtl/drvspi_msg_handler.sv
module drvspi_msg_handler
   import drvspi_pkg::*;
#(
   parameter int NUM_PARAMS  = 16,
   parameter int FLAG_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         spi_sclk,
   input  logic                         spi_cs_n,
   input  logic                         spi_mosi,
   output logic                         spi_miso,
   input  logic [FLAG_W-1:0]            prot_flags,
   input  logic [WORD_W-1:0]            phase_current,
   output logic [WORD_W-1:0]            cyc_index,
   input  logic [WORD_W-1:0]            cyc_value,
   output logic [NUM_PARAMS*WORD_W-1:0] param_bus
);
   localparam int ADDR_W = $clog2(NUM_PARAMS);

   if (NUM_PARAMS < 2 || NUM_PARAMS > 256) begin : g_chk_np
      $error("NUM_PARAMS must be within 2..256");
   end
   if (FLAG_W < 1 || FLAG_W > WORD_W-2) begin : g_chk_fw
      $error("FLAG_W must leave the error bit and one spare bit free");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              frame_start_w, frame_end_w, word_valid_w, aligned_w, tx_load_w;
   word_t             rx_word_w, status_w, tx_next_w, rd_data_w, wr_data_w;
   logic              wr_en_w;
   logic [ADDR_W-1:0] wr_addr_w, rd_addr_w;

   drvspi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk        (spi_sclk),
      .cs_n        (spi_cs_n),
      .mosi        (spi_mosi),
      .miso        (spi_miso),
      .frame_start (frame_start_w),
      .frame_end   (frame_end_w),
      .word_valid  (word_valid_w),
      .rx_word     (rx_word_w),
      .aligned     (aligned_w),
      .tx_load     (tx_load_w),
      .tx_first    (status_w),
      .tx_next     (tx_next_w)
   );

   drvspi_engine #(.NUM_PARAMS(NUM_PARAMS), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start_w),
      .frame_end   (frame_end_w),
      .word_valid  (word_valid_w),
      .rx_word     (rx_word_w),
      .aligned     (aligned_w),
      .tx_load     (tx_load_w),
      .flags       (prot_flags),
      .cur_sample  (phase_current),
      .cyc_data    (cyc_value),
      .rd_param    (rd_data_w),
      .status      (status_w),
      .tx_next     (tx_next_w),
      .cyc_idx     (cyc_index),
      .rd_addr     (rd_addr_w),
      .wr_en       (wr_en_w),
      .wr_addr     (wr_addr_w),
      .wr_data     (wr_data_w)
   );

   drvspi_params #(.NUM_PARAMS(NUM_PARAMS), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en_w),
      .wr_addr     (wr_addr_w),
      .wr_data     (wr_data_w),
      .rd_addr     (rd_addr_w),
      .rd_data     (rd_data_w),
      .params_flat (param_bus)
   );
endmodule

// File: rtl/drvspi_checker.sv
module drvspi_checker
   import drvspi_pkg::*;
#(
   parameter int NUM_PARAMS = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cs_n,
   input logic                         miso,
   input logic [NUM_PARAMS*WORD_W-1:0] param_bus,
   input logic                         wr_en,
   input logic                         aligned,
   input logic                         frame_start,
   input logic                         frame_end,
   input logic                         word_valid,
   input logic                         tx_load,
   input word_t                        status
);
   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso); // R1

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frame_start, word_valid, tx_load})); // R2

   AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> aligned); // R2

   AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(param_bus) |-> $past(wr_en)); // R3

   AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status[WORD_W-1]) |-> $past(frame_end)); // R4

   AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (frame_end && aligned)); // R9
endmodule

bind drvspi_msg_handler drvspi_checker #(.NUM_PARAMS(NUM_PARAMS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (spi_cs_n),
   .miso        (spi_miso),
   .param_bus   (param_bus),
   .wr_en       (wr_en_w),
   .aligned     (aligned_w),
   .frame_start (frame_start_w),
   .frame_end   (frame_end_w),
   .word_valid  (word_valid_w),
   .tx_load     (tx_load_w),
   .status      (status_w)
);

// File: tb/tb_drvspi_msg_handler.sv
module tb_drvspi_msg_handler;
   import drvspi_pkg::*;

   localparam int NP   = 16;
   localparam int FW   = 8;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso;
   logic [FW-1:0] flags = '0;
   word_t cur = '0;
   word_t cyc_idx, cyc_val;
   logic [NP*WORD_W-1:0] pbus;

   always #10 clk = ~clk;

   function automatic word_t var_of(word_t i);
      return i ^ 16'h5A00;
   endfunction
   assign cyc_val = var_of(cyc_idx);

   drvspi_msg_handler #(.NUM_PARAMS(NP), .FLAG_W(FW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .prot_flags(flags), .phase_current(cur),
      .cyc_index(cyc_idx), .cyc_value(cyc_val), .param_bus(pbus)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(bit ok, string tag, word_t act, word_t exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   typedef struct {
      word_t w;
      string tag;
   } exp_t;
   exp_t  expq[$];
   word_t got_w;
   event  got_ev;

   // scoreboard monitor
   initial begin
      forever begin
         @(got_ev);
         if (expq.size() == 0) begin
            check(1'b0, "SCOREBOARD", got_w, '0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(got_w === e.w, e.tag, got_w, e.w);
         end
      end
   end

   word_t m_param[NP];
   bit    m_err = 1'b0;

   function automatic word_t status_of();
      word_t s;
      s = '0;
      s[FW-1:0] = flags;
      s[15] = m_err;
      return s;
   endfunction

   task automatic xfer_word(input word_t tx, input int nbits, output word_t rx);
      rx = '0;
      for (int b = 15; b >= 16 - nbits; b--) begin
         mosi = tx[b];
         repeat (HALF) @(negedge clk);
         sclk = 1'b1;
         rx[b] = miso;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   // driver: pushes expected words, then runs the frame
   task automatic frame(input word_t w[5], input int nw, input int pbits,
                        input string tagd, input string tagc);
      word_t o[5];
      word_t s3, rx;
      bit bad;
      s3 = w[0] + w[1] + w[2];
      o[0] = status_of();
      o[1] = (w[0] == MSG_EXCH) ? cur : '0;
      if (w[0] == MSG_EXCH)      o[2] = var_of(w[1]);
      else if (w[0] == MSG_READ) o[2] = (w[1] < NP) ? m_param[w[1][3:0]] : var_of(w[1]);
      else                       o[2] = '0;
      bad = ((w[0] == MSG_READ) || (w[0] == MSG_EXCH)) && (s3 != '0);
      o[3] = (word_t'(0) - (o[0] + o[1] + o[2])) ^ (bad ? 16'hFFFF : 16'h0000);
      o[4] = '0;
      for (int i = 0; i < nw; i++) begin
         exp_t e;
         e.w = o[i];
         e.tag = (i == 0) ? "R2 status" : (i == 3) ? tagc : (i == 4) ? "R9 extra" : tagd;
         expq.push_back(e);
      end
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nw; i++) begin
         xfer_word(w[i], 16, rx);
         got_w = rx;
         -> got_ev;
      end
      if (pbits > 0) xfer_word(w[nw], pbits, rx);
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (4 * HALF) @(negedge clk);
      if (w[0] == MSG_WRITE && nw == 4 && pbits == 0) begin
         if ((s3 + w[3]) == '0 && w[1] < NP) begin
            m_param[w[1][3:0]] = w[2];
            m_err = 1'b0;
         end else begin
            m_err = 1'b1;
         end
      end
   endtask

   function automatic word_t ck(word_t a, word_t b, word_t c);
      return word_t'(0) - (a + b + c);
   endfunction

   task automatic check_params(string tag);
      for (int k = 0; k < NP; k++)
         check(pbus[k*16 +: 16] === m_param[k], tag, pbus[k*16 +: 16], m_param[k]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "WATCHDOG", '0, '0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int k = 0; k < NP; k++) m_param[k] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      check(miso === 1'b0, "R1 miso idle", word_t'(miso), '0);
      check_params("R1 params reset");
      flags = 8'h21;
      cur   = 16'h1234;

      frame('{MSG_READ, 16'd3, ck(MSG_READ, 16'd3, 0), 0, 0}, 4, 0, "R5 read zero", "R7 csum");
      frame('{MSG_WRITE, 16'd3, 16'hBEEF, ck(MSG_WRITE, 16'd3, 16'hBEEF), 0}, 4, 0, "R3 write resp", "R7 csum");
      check_params("R3 commit");
      frame('{MSG_WRITE, 16'd15, 16'h0F0F, ck(MSG_WRITE, 16'd15, 16'h0F0F), 0}, 4, 0, "R3 write top", "R7 csum");
      check_params("R3 commit top addr");
      frame('{MSG_READ, 16'd3, ck(MSG_READ, 16'd3, 0), 0, 0}, 4, 0, "R5 readback", "R7 csum");
      // R4 bad checksum write
      frame('{MSG_WRITE, 16'd5, 16'h1111, 16'h0000, 0}, 4, 0, "R4 bad write", "R7 csum");
      check_params("R4 no commit");
      frame('{MSG_EXCH, 16'h0042, ck(MSG_EXCH, 16'h0042, 0), 0, 0}, 4, 0, "R6 exchange", "R7 csum");
      check(m_err == 1'b1, "R4 model err", word_t'(m_err), 16'd1);
      frame('{MSG_WRITE, 16'd7, 16'hA5A5, ck(MSG_WRITE, 16'd7, 16'hA5A5), 0}, 4, 0, "R3 write clr", "R7 csum");
      check_params("R3 commit clr");
      frame('{MSG_EXCH, 16'h0010, 16'h0BAD, 0, 0}, 4, 0, "R6 exchange", "R8 inverted exch");
      frame('{MSG_READ, 16'd7, 16'h0001, 0, 0}, 4, 0, "R5 read", "R8 inverted read");
      frame('{MSG_READ, 16'h0100, ck(MSG_READ, 16'h0100, 0), 0, 0}, 4, 0, "R5 variable", "R7 csum");
      // R4 out of range address
      frame('{MSG_WRITE, 16'd20, 16'h2222, ck(MSG_WRITE, 16'd20, 16'h2222), 0}, 4, 0, "R4 range", "R7 csum");
      check_params("R4 range no commit");
      frame('{MSG_WRITE, 16'd9, 16'h3333, ck(MSG_WRITE, 16'd9, 16'h3333), 0}, 4, 0, "R3 write", "R7 csum");
      // R9 truncated, partial and overlong writes
      frame('{MSG_WRITE, 16'd9, 16'h4444, ck(MSG_WRITE, 16'd9, 16'h4444), 0}, 3, 0, "R9 short", "R9 short");
      frame('{MSG_WRITE, 16'd9, 16'h5555, ck(MSG_WRITE, 16'd9, 16'h5555), 0}, 3, 5, "R9 partial", "R9 partial");
      frame('{MSG_WRITE, 16'd9, 16'h6666, ck(MSG_WRITE, 16'd9, 16'h6666), 16'h0}, 5, 0, "R9 long", "R7 csum");
      check_params("R9 no commit");
      frame('{MSG_READ, 16'd9, ck(MSG_READ, 16'd9, 0), 0, 0}, 4, 0, "R9 readback", "R7 csum");
      // R10 unknown id
      frame('{16'h0077, 16'd9, 16'h7777, ck(16'h0077, 16'd9, 16'h7777), 0}, 4, 0, "R10 unknown", "R10 csum");
      check_params("R10 no change");
      flags = 8'hC3;
      cur   = 16'hFEDC;
      frame('{MSG_EXCH, 16'hFFFF, ck(MSG_EXCH, 16'hFFFF, 0), 0, 0}, 4, 0, "R6 exchange 2", "R7 csum");
      check(miso === 1'b0, "R1 miso idle end", word_t'(miso), '0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule